// File: doc/BRIEF.md
# OTP Indirect-Access Command Controller

This block lets a processor operate a one-time-programmable (OTP) memory through a small register file on an APB slave port. It does not map the memory into the address space. Software first stages an instruction word, which holds an OTP line address and a 5-bit opcode. It then loads the program-data words or the mode-register source words and writes any value to an execute register. The controller checks the opcode and sends one command to the OTP side. It holds a busy flag until the OTP side reports completion.

When the OTP side completes, the controller latches the three OTP error flags into the status register. For a read, it also places the returned 128-bit line into four readback words. The staged registers keep their values for the whole operation, so the command fields stay stable while the memory works. An opcode that the decoder does not know is rejected without starting anything, and a status flag records the rejection.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero: the instruction word, the status word, the mode sources, the program words and the readback words. `cmdStart` is low.
- R2: The instruction register (offset 0x00) holds the opcode in bits [4:0] and the line address in bits [8 +: ADDR_W]. Both fields read back as written, and they drive `cmdOp` and `cmdAddr`.
- R3: A write of any value to the execute register (offset 0x04) while idle, with a legal opcode staged, does two things in the cycle after the APB access phase. It raises `cmdStart` for exactly one cycle, and it sets the busy bit (status offset 0x08, bit 0).
- R4: While busy, a `rspDone` pulse clears busy. The same pulse loads `rspErr` into status bits [4:2].
- R5: On completion of opcode 0x02 (read), readback word k (offset 0x40 + 4k) takes `rspData[32k +: 32]`. Completion of any other opcode leaves the readback words unchanged.
- R6: `cmdWdata[32k +: 32]` equals program-data word k (offset 0x20 + 4k) for k = 0 .. WR_WORDS-1.
- R7: `cmdModeData` carries the main mode source (offset 0x10) when opcode 0x0C is staged. For any other opcode, including 0x05 and 0x0B, it carries the shared A/B mode source (offset 0x0C).
- R8: A write to the execute register while busy is ignored. No further `cmdStart` is produced.
- R9: While busy, writes to the instruction, mode-source and program-data registers are ignored.
- R10: An execute write with opcode 0x00 or 0x0D..0x1F sets the illegal-instruction status bit (bit 1). Busy is not set, and `cmdStart` is not raised.
- R11: An execute write accepted while idle clears the error flags. An execute write that launches an operation also clears the illegal-instruction bit.
- R12: Each opcode 0x01 to 0x0C is accepted and presented unchanged on `cmdOp`. The opcodes are: 0x01 program and verify, 0x02 read, 0x03 basic program, 0x04 data-register write, 0x05 mode A, 0x06 compare, 0x07 precharge, 0x08 self-test reset, 0x09 stress test, 0x0A clean-array test, 0x0B mode B, 0x0C main mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high; no wait states |
| cmdStart | output | 1 | One-cycle command launch to the OTP side |
| cmdOp | output | 5 | Staged opcode |
| cmdAddr | output | ADDR_W | Staged OTP line address |
| cmdWdata | output | 32*WR_WORDS | Program data words, word 0 at the bottom |
| cmdModeData | output | 32 | Mode-register source selected by the opcode |
| rspDone | input | 1 | Completion pulse from the OTP side |
| rspData | input | 32*RD_WORDS | Line returned by a read |
| rspErr | input | 3 | Error flags reported at completion |

## Verification
The bench builds the block with ADDR_W=12 rather than the default 10. This makes the address field reach bit 19 of the instruction word, so a field placed at the wrong position or cut short shows up on read-back and on `cmdAddr`. It keeps WR_WORDS=5 and RD_WORDS=4. With those values every program word is checked through the full 160-bit command bus, and every readback word is checked against its 32-bit slice of a 128-bit line with distinct nibbles. Illegal opcodes are tried at both ends of the rejected range.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  localparam int REG_AW   = 8;
  localparam int OP_W     = 5;
  localparam int ERR_W    = 3;
  localparam int ADDR_LSB = 8;

  localparam logic [REG_AW-1:0] OFS_INSTR  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_EXEC   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h08;
  localparam logic [REG_AW-1:0] OFS_MODEAB = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_MODE   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_DATA   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_Q      = 8'h40;

  localparam logic [OP_W-1:0] OP_READ  = 5'h02;
  localparam logic [OP_W-1:0] OP_MR    = 5'h0C;
  localparam logic [OP_W-1:0] OP_FIRST = 5'h01;
  localparam logic [OP_W-1:0] OP_LAST  = 5'h0C;

  typedef struct packed {
    logic stageWr;
    logic launch;
    logic reject;
    logic finish;
    logic capRead;
  } ctlStrobe_t;

  function automatic logic opLegal(input logic [OP_W-1:0] op);
    return (op >= OP_FIRST) && (op <= OP_LAST);
  endfunction
endpackage

// File: rtl/otp_cmd_ctrl_fsm.sv
module otp_cmd_ctrl_fsm
  import otp_cmd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    apbWr,
  input  logic [REG_AW-1:0]       apbAddr,
  input  logic [OP_W-1:0]         opcode,
  input  logic                    rspDone,
  output logic                    busy,
  output logic                    cmdStart,
  output ctlStrobe_t              strobe
);
  logic execHit;

  always_comb begin
    execHit        = apbWr && (apbAddr == OFS_EXEC) && !busy;
    strobe.stageWr = apbWr && !busy;
    strobe.launch  = execHit && opLegal(opcode);
    strobe.reject  = execHit && !opLegal(opcode);
    strobe.finish  = busy && rspDone;
    strobe.capRead = busy && rspDone && (opcode == OP_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cmdStart <= 1'b0;
    end else begin
      cmdStart <= strobe.launch;
      if (strobe.launch)      busy <= 1'b1;
      else if (strobe.finish) busy <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R3
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> busy); // R3
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rspDone) |=> !busy); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && apbWr && apbAddr == OFS_EXEC) |=> !cmdStart); // R8
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reject |=> (!busy && !cmdStart)); // R10
endmodule

// File: rtl/otp_cmd_ctrl_regs.sv
module otp_cmd_ctrl_regs
  import otp_cmd_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WR_WORDS = 5,
  parameter int RD_WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic                       busy,
  input  logic [REG_AW-1:0]          apbAddr,
  input  logic [31:0]                apbWdata,
  output logic [31:0]                rdData,
  output logic [OP_W-1:0]            opcode,
  output logic [ADDR_W-1:0]          lineAddr,
  output logic [32*WR_WORDS-1:0]     wrData,
  output logic [31:0]                modeData,
  input  logic [32*RD_WORDS-1:0]     rspData,
  input  logic [ERR_W-1:0]           rspErr
);
  logic [WR_WORDS-1:0][31:0] dataWords;
  logic [RD_WORDS-1:0][31:0] qWords;
  logic [31:0]               modeAB;
  logic [31:0]               modeMain;
  logic                      illegalFlag;
  logic [ERR_W-1:0]          errFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode   <= '0;
      lineAddr <= '0;
      modeAB   <= '0;
      modeMain <= '0;
    end else if (strobe.stageWr) begin
      if (apbAddr == OFS_INSTR) begin
        opcode   <= apbWdata[OP_W-1:0];
        lineAddr <= apbWdata[ADDR_LSB +: ADDR_W];
      end
      if (apbAddr == OFS_MODEAB) modeAB   <= apbWdata;
      if (apbAddr == OFS_MODE)   modeMain <= apbWdata;
    end
  end

  for (genvar g = 0; g < WR_WORDS; g++) begin : gDataw
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dataWords[g] <= '0;
      else if (strobe.stageWr && apbAddr == REG_AW'(OFS_DATA + 4*g))
        dataWords[g] <= apbWdata;
    end
  end

  for (genvar g = 0; g < RD_WORDS; g++) begin : gReadback
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) qWords[g] <= '0;
      else if (strobe.capRead) qWords[g] <= rspData[32*g +: 32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      illegalFlag <= 1'b0;
      errFlags    <= '0;
    end else if (strobe.launch) begin
      illegalFlag <= 1'b0;
      errFlags    <= '0;
    end else if (strobe.reject) begin
      illegalFlag <= 1'b1;
      errFlags    <= '0;
    end else if (strobe.finish) begin
      errFlags    <= rspErr;
    end
  end

  assign wrData   = dataWords;
  assign modeData = (opcode == OP_MR) ? modeMain : modeAB;

  always_comb begin
    rdData = '0;
    unique case (apbAddr)
      OFS_INSTR: begin
        rdData[OP_W-1:0]            = opcode;
        rdData[ADDR_LSB +: ADDR_W]  = lineAddr;
      end
      OFS_STAT:   rdData[ERR_W+1:0] = {errFlags, illegalFlag, busy};
      OFS_MODEAB: rdData = modeAB;
      OFS_MODE:   rdData = modeMain;
      default: ;
    endcase
    for (int i = 0; i < WR_WORDS; i++)
      if (apbAddr == REG_AW'(OFS_DATA + 4*i)) rdData = dataWords[i];
    for (int i = 0; i < RD_WORDS; i++)
      if (apbAddr == REG_AW'(OFS_Q + 4*i)) rdData = qWords[i];
  end

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> ($stable(opcode) && $stable(lineAddr) && $stable(dataWords))); // R9
  AST_Q_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busy) |-> $stable(qWords)); // R5
  AST_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |=> (errFlags == '0 && !illegalFlag)); // R11
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WR_WORDS = 5,
  parameter int RD_WORDS = 4
) (
  input  logic                    pclk,
  input  logic                    presetn,
  input  logic                    psel,
  input  logic                    penable,
  input  logic                    pwrite,
  input  logic [REG_AW-1:0]       paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  output logic                    pready,
  output logic                    cmdStart,
  output logic [OP_W-1:0]         cmdOp,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic [32*WR_WORDS-1:0]  cmdWdata,
  output logic [31:0]             cmdModeData,
  input  logic                    rspDone,
  input  logic [32*RD_WORDS-1:0]  rspData,
  input  logic [ERR_W-1:0]        rspErr
);
  ctlStrobe_t strobe;
  logic       busy;
  logic       apbWr;

  assign apbWr  = psel && penable && pwrite;
  assign pready = 1'b1;

  otp_cmd_ctrl_fsm u_fsm (
    .clk(pclk), .rstN(presetn), .apbWr(apbWr), .apbAddr(paddr),
    .opcode(cmdOp), .rspDone(rspDone), .busy(busy),
    .cmdStart(cmdStart), .strobe(strobe)
  );

  otp_cmd_ctrl_regs #(.ADDR_W(ADDR_W), .WR_WORDS(WR_WORDS), .RD_WORDS(RD_WORDS)) u_regs (
    .clk(pclk), .rstN(presetn), .strobe(strobe), .busy(busy),
    .apbAddr(paddr), .apbWdata(pwdata), .rdData(prdata),
    .opcode(cmdOp), .lineAddr(cmdAddr), .wrData(cmdWdata),
    .modeData(cmdModeData), .rspData(rspData), .rspErr(rspErr)
  );
endmodule

// File: tb/otp_cmd_ctrl_bench.sv
module otp_cmd_ctrl_bench;
  localparam int AW = 12;
  localparam int WW = 5;
  localparam int RW = 4;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, cmdStart, rspDone = 1'b0;
  logic [4:0] cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [32*WW-1:0] cmdWdata;
  logic [31:0] cmdModeData;
  logic [32*RW-1:0] rspData = '0;
  logic [2:0] rspErr = '0;

  int checks = 0, failures = 0, startCount = 0;

  always #2 pclk = ~pclk;
  always @(negedge pclk) if (cmdStart) startCount++;

  otp_cmd_ctrl #(.ADDR_W(AW), .WR_WORDS(WW), .RD_WORDS(RW)) u_otp_cmd_ctrl (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata),
    .cmdModeData(cmdModeData), .rspDone(rspDone), .rspData(rspData), .rspErr(rspErr)
  );

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic respond(input logic [127:0] data, input logic [2:0] err);
    @(negedge pclk); rspDone = 1; rspData = data; rspErr = err;
    @(negedge pclk); rspDone = 0;
  endtask

  function automatic logic [31:0] instrWord(input logic [AW-1:0] a, input logic [4:0] op);
    return (32'(a) << 8) | 32'(op);
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    apbRead(8'h00, v); chk("R1 instr", v, 0);
    apbRead(8'h08, v); chk("R1 stat", v, 0);
    apbRead(8'h40, v); chk("R1 q0", v, 0);
    apbRead(8'h20, v); chk("R1 data0", v, 0);
    apbRead(8'h0C, v); chk("R1 modeab", v, 0);
    chk("R1 cmdStart", cmdStart, 0);
  endtask

  task automatic t_instr;
    logic [31:0] v;
    apbWrite(8'h00, instrWord(12'hABC, 5'h02) | 32'hF000_00E0);
    apbRead(8'h00, v); chk("R2 readback", v, instrWord(12'hABC, 5'h02));
    chk("R2 cmdAddr", cmdAddr, 12'hABC);
    chk("R2 cmdOp", cmdOp, 5'h02);
  endtask

  task automatic t_read;
    logic [31:0] v;
    int s0;
    s0 = startCount;
    apbWrite(8'h04, 32'h1234_5678);
    chk("R3 start high", cmdStart, 1);
    @(negedge pclk); chk("R3 start one cycle", cmdStart, 0);
    chk("R3 one start", startCount - s0, 1);
    apbRead(8'h08, v); chk("R3 busy", v, 32'h1);
    respond(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 3'b000);
    apbRead(8'h08, v); chk("R4 idle no err", v, 0);
    apbRead(8'h40, v); chk("R5 q0", v, 32'h7654_3210);
    apbRead(8'h44, v); chk("R5 q1", v, 32'hFEDC_BA98);
    apbRead(8'h48, v); chk("R5 q2", v, 32'h89AB_CDEF);
    apbRead(8'h4C, v); chk("R5 q3", v, 32'h0123_4567);
  endtask

  task automatic t_prog;
    logic [31:0] v;
    logic [159:0] exp;
    for (int i = 0; i < WW; i++) begin
      apbWrite(8'(8'h20 + 4*i), 32'hD000_0000 + 32'(i * 32'h0101_0101));
      exp[32*i +: 32] = 32'hD000_0000 + 32'(i * 32'h0101_0101);
    end
    chk("R6 wdata", cmdWdata, exp);
    apbWrite(8'h00, instrWord(12'h005, 5'h01));
    apbWrite(8'h04, 32'h0);
    chk("R3 prog start", cmdStart, 1);
    respond(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 3'b101);
    apbRead(8'h08, v); chk("R4 err flags", v, 32'h14);
    apbRead(8'h40, v); chk("R5 q0 kept after prog", v, 32'h7654_3210);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    int s0;
    apbWrite(8'h00, instrWord(12'h033, 5'h03));
    s0 = startCount;
    apbWrite(8'h04, 32'h1);
    apbRead(8'h08, v); chk("R11 err cleared on launch", v, 32'h1);
    apbWrite(8'h04, 32'h2);
    apbWrite(8'h00, instrWord(12'h777, 5'h07));
    apbWrite(8'h20, 32'hBAD0_BAD0);
    apbWrite(8'h0C, 32'hBAD1_BAD1);
    chk("R8 single start", startCount - s0, 1);
    apbRead(8'h00, v); chk("R9 instr held", v, instrWord(12'h033, 5'h03));
    apbRead(8'h20, v); chk("R9 data held", v, 32'hD000_0000);
    apbRead(8'h0C, v); chk("R9 modeab held", v, 0);
    chk("R9 cmdOp held", cmdOp, 5'h03);
    respond(128'h0, 3'b000);
    apbRead(8'h08, v); chk("R4 idle", v, 0);
  endtask

  task automatic t_mode;
    apbWrite(8'h0C, 32'h1111_AAAA);
    apbWrite(8'h10, 32'h2222_BBBB);
    apbWrite(8'h00, instrWord(12'h0, 5'h05)); chk("R7 mode A", cmdModeData, 32'h1111_AAAA);
    apbWrite(8'h00, instrWord(12'h0, 5'h0C)); chk("R7 main mode", cmdModeData, 32'h2222_BBBB);
    apbWrite(8'h00, instrWord(12'h0, 5'h0B)); chk("R7 mode B", cmdModeData, 32'h1111_AAAA);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    int s0;
    s0 = startCount;
    apbWrite(8'h00, instrWord(12'h010, 5'h0D));
    apbWrite(8'h04, 32'h0);
    apbRead(8'h08, v); chk("R10 illegal 0x0D", v, 32'h2);
    apbWrite(8'h00, instrWord(12'h010, 5'h00));
    apbWrite(8'h04, 32'h0);
    apbRead(8'h08, v); chk("R10 illegal 0x00", v, 32'h2);
    apbWrite(8'h00, instrWord(12'h010, 5'h1F));
    apbWrite(8'h04, 32'h0);
    apbRead(8'h08, v); chk("R10 illegal 0x1F", v, 32'h2);
    chk("R10 no start", startCount - s0, 0);
    apbWrite(8'h00, instrWord(12'h010, 5'h06));
    apbWrite(8'h04, 32'h0);
    apbRead(8'h08, v); chk("R11 illegal cleared", v, 32'h1);
    respond(128'h0, 3'b010);
    apbRead(8'h08, v); chk("R4 err after cmp", v, 32'h8);
  endtask

  task automatic t_allops;
    logic [31:0] v;
    for (int op = 1; op <= 12; op++) begin
      apbWrite(8'h00, instrWord(12'(op * 3), 5'(op)));
      apbWrite(8'h04, 32'h0);
      chk("R12 start", cmdStart, 1);
      chk("R12 op", cmdOp, 5'(op));
      respond(128'h0, 3'b000);
      apbRead(8'h08, v); chk("R12 done", v, 0);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge pclk);
        t_reset;
        presetn = 1'b1;
        @(negedge pclk);
        t_reset;
        t_instr;
        t_read;
        t_prog;
        t_busy;
        t_mode;
        t_illegal;
        t_allops;
      end
      begin
        repeat (100000) @(posedge pclk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule